// File: doc/BRIEF.md
# Cipher Engine Control Register Bank with Write Lock

This block is the software-facing register bank of a block-cipher accelerator. A simple register bus (write enable, read enable, word address, write data, registered read data) reaches a control word with the engine configuration: enable, data swap type, operating mode, chaining mode, input and output DMA enables, authenticated-mode phase, key size, key protection, key mode, share target, key select and a software reset bit. The cipher datapath is outside the block. Its state arrives as three status inputs: busy, computing and input phase. The block also takes the 32-bit result word that the engine offers for output reads.

Configuration writes are guarded. A write is dropped while the engine is busy. It is also dropped when the engine was already enabled and the same write keeps the enable bit set. A read of the output data word at the wrong moment (during computation or during the input phase) returns zero and raises a sticky read-error flag. The engine is not disturbed. The flag can raise an interrupt, and software clears it with a write-one-to-clear register. The software reset bit returns the bank to its defaults, except for the reset bit itself and an access-configuration register.

Top module: `crypto_ctrl_regs`

## Requirements
- R1: After reset, the control word (address 0), the status word (address 1) and the interrupt enable (address 2) read as zero, and en_o, rd_err_o and irq_o are low.
- R2: With busy_i low and EN (control bit 0) low, a write to address 0 stores the data masked to the implemented bits (mask 0xFF0D787F). The stored value reads back on the next read of address 0. Fields in the control word: swap type [2:1], mode [4:3], input DMA bit 11, output DMA bit 12, phase [14:13], key size bit 18, key protection bit 19, key mode [25:24], share target [27:26], key select [30:28].
- R3: The 3-bit chaining mode is taken from control bits {16, 6, 5}, with bit 16 as the most significant bit. The encodings are 0 ECB, 1 CBC, 2 CTR, 3 GCM/GMAC and 4 CCM.
- R4: While busy_i is high, a control write with bit 31 clear leaves the whole control word unchanged.
- R5: When EN is 1 before a control write and that write has bit 0 set, the write is ignored. A write that clears bit 0 is accepted in full, together with its other fields.
- R6: A read of address 4 while computing_i or input_phase_i is high returns zero and sets rd_err_o on the following clock edge. Any other read of address 4 returns dout_data_i and leaves rd_err_o unchanged.
- R7: Writing address 3 with bit 0 set clears rd_err_o.
- R8: irq_o is the read-error flag ANDed with interrupt enable bit 0 (address 2), registered, so it follows that product one cycle late.
- R9: The status word (address 1) reads busy_i in bit 0 and rd_err_o in bit 1. Writes to it have no effect.
- R10: Writing control bit 31 as 1 sets the reset bit even when the engine is busy or locked. In the same edge it clears all other control bits, the interrupt enable, rd_err_o and irq_o. While the reset bit is set, writes to addresses 2, 3 and 5 are ignored. A control write with bit 31 clear releases the reset and leaves the control word at zero. The access configuration at address 5 keeps its value through the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after rd_en_i |
| busy_i | input | 1 | Engine busy |
| computing_i | input | 1 | Engine computing |
| input_phase_i | input | 1 | Engine in data input phase |
| dout_data_i | input | 32 | Engine output data word |
| en_o | output | 1 | Engine enable |
| mode_o | output | 2 | Operating mode |
| chmod_o | output | 3 | Chaining mode |
| key_sel_o | output | 3 | Key source select |
| dma_in_en_o | output | 1 | Input DMA enable |
| access_cfg_o | output | ACW | Access configuration register |
| rd_err_o | output | 1 | Read-error flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus never raises a read and a write in the same cycle. They also assume that the status inputs change only between edges and not as a result of bus traffic. The stimulus keeps to this by driving one bus operation per call, always on the falling edge. Busy, computing and input phase are raised only around operations that test them, and dropped again before the next unrelated operation. The bench compares every read against a queue of expected words built from the requirements, and checks the direct outputs at the same falling edge.

// File: rtl/crypto_ctrl_pkg.sv
package crypto_ctrl_pkg;
  localparam int unsigned CW = 32;
  localparam logic [CW-1:0] CTRL_WR_MASK = 32'hFF0D_787F;
  localparam int unsigned EN_BIT   = 0;
  localparam int unsigned SRST_BIT = 31;

  localparam int unsigned ADDR_CTRL = 0;
  localparam int unsigned ADDR_STAT = 1;
  localparam int unsigned ADDR_IE   = 2;
  localparam int unsigned ADDR_ICR  = 3;
  localparam int unsigned ADDR_DOUT = 4;
  localparam int unsigned ADDR_ACC  = 5;

  typedef enum logic [2:0] {
    CH_ECB = 3'd0,
    CH_CBC = 3'd1,
    CH_CTR = 3'd2,
    CH_GCM = 3'd3,
    CH_CCM = 3'd4
  } chain_e;
endpackage

// File: rtl/ctrl_word_reg.sv
module ctrl_word_reg
  import crypto_ctrl_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          busy_i,
  output logic [CW-1:0] ctrl_o
);
  logic [CW-1:0] ctrl_q;
  logic          locked;

  // lock rule uses EN as held before this write
  assign locked = busy_i | (ctrl_q[EN_BIT] & wdata_i[EN_BIT]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      if (wdata_i[SRST_BIT]) begin
        ctrl_q <= CW'(1) << SRST_BIT;
      end else if (ctrl_q[SRST_BIT]) begin
        ctrl_q <= '0;
      end else if (!locked) begin
        ctrl_q <= wdata_i & CTRL_WR_MASK;
      end
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/rd_err_irq.sv
module rd_err_irq (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic srst_i,
  input  logic set_i,
  input  logic clr_i,
  input  logic ie_i,
  output logic flag_o,
  output logic irq_o
);
  logic flag_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else if (srst_i) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      if (set_i)      flag_q <= 1'b1;
      else if (clr_i) flag_q <= 1'b0;
      irq_q <= flag_q & ie_i;
    end
  end

  assign flag_o = flag_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/bus_rd_mux.sv
module bus_rd_mux
  import crypto_ctrl_pkg::*;
#(
  parameter int unsigned AW  = 4,
  parameter int unsigned ACW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [CW-1:0]  ctrl_i,
  input  logic           busy_i,
  input  logic           flag_i,
  input  logic           ie_i,
  input  logic           dout_block_i,
  input  logic [CW-1:0]  dout_data_i,
  input  logic [ACW-1:0] acc_i,
  output logic [CW-1:0]  rdata_o
);
  logic [CW-1:0] rd_d, rdata_q;

  always_comb begin
    rd_d = '0;
    if (addr_i == AW'(ADDR_CTRL))      rd_d = ctrl_i;
    else if (addr_i == AW'(ADDR_STAT)) rd_d = {{(CW-2){1'b0}}, flag_i, busy_i};
    else if (addr_i == AW'(ADDR_IE))   rd_d = {{(CW-1){1'b0}}, ie_i};
    else if (addr_i == AW'(ADDR_DOUT)) rd_d = dout_block_i ? '0 : dout_data_i;
    else if (addr_i == AW'(ADDR_ACC))  rd_d = CW'(acc_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rd_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/crypto_ctrl_regs.sv
module crypto_ctrl_regs
  import crypto_ctrl_pkg::*;
#(
  parameter int unsigned AW  = 4,
  parameter int unsigned ACW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           wr_en_i,
  input  logic           rd_en_i,
  input  logic [AW-1:0]  addr_i,
  input  logic [31:0]    wdata_i,
  output logic [31:0]    rdata_o,
  input  logic           busy_i,
  input  logic           computing_i,
  input  logic           input_phase_i,
  input  logic [31:0]    dout_data_i,
  output logic           en_o,
  output logic [1:0]     mode_o,
  output logic [2:0]     chmod_o,
  output logic [2:0]     key_sel_o,
  output logic           dma_in_en_o,
  output logic [ACW-1:0] access_cfg_o,
  output logic           rd_err_o,
  output logic           irq_o
);
  logic [CW-1:0]  ctrl;
  logic           srst_q, srst_now, dout_block;
  logic           we_ctrl, we_ie, we_icr, we_acc, err_set;
  logic           ie_q;
  logic [ACW-1:0] acc_q;

  assign srst_q     = ctrl[SRST_BIT];
  assign we_ctrl    = wr_en_i & (addr_i == AW'(ADDR_CTRL));
  assign we_ie      = wr_en_i & (addr_i == AW'(ADDR_IE))  & ~srst_q;
  assign we_icr     = wr_en_i & (addr_i == AW'(ADDR_ICR)) & ~srst_q;
  assign we_acc     = wr_en_i & (addr_i == AW'(ADDR_ACC)) & ~srst_q;
  assign srst_now   = srst_q | (we_ctrl & wdata_i[SRST_BIT]);
  assign dout_block = computing_i | input_phase_i;
  assign err_set    = rd_en_i & (addr_i == AW'(ADDR_DOUT)) & dout_block & ~srst_q;

  ctrl_word_reg u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we_ctrl),
    .wdata_i (wdata_i),
    .busy_i  (busy_i),
    .ctrl_o  (ctrl)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       ie_q <= 1'b0;
    else if (srst_now) ie_q <= 1'b0;
    else if (we_ie)    ie_q <= wdata_i[0];
  end

  // access configuration survives the software reset
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (we_acc) acc_q <= wdata_i[ACW-1:0];
  end

  rd_err_irq u_err (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .srst_i (srst_now),
    .set_i  (err_set),
    .clr_i  (we_icr & wdata_i[0]),
    .ie_i   (ie_q),
    .flag_o (rd_err_o),
    .irq_o  (irq_o)
  );

  bus_rd_mux #(.AW(AW), .ACW(ACW)) u_rd (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rd_en_i      (rd_en_i),
    .addr_i       (addr_i),
    .ctrl_i       (ctrl),
    .busy_i       (busy_i),
    .flag_i       (rd_err_o),
    .ie_i         (ie_q),
    .dout_block_i (dout_block),
    .dout_data_i  (dout_data_i),
    .acc_i        (acc_q),
    .rdata_o      (rdata_o)
  );

  assign en_o         = ctrl[EN_BIT];
  assign mode_o       = ctrl[4:3];
  assign chmod_o      = {ctrl[16], ctrl[6:5]};
  assign key_sel_o    = ctrl[30:28];
  assign dma_in_en_o  = ctrl[11];
  assign access_cfg_o = acc_q;
endmodule

// File: rtl/crypto_ctrl_regs_chk.sv
module crypto_ctrl_regs_chk #(
  parameter int unsigned AW  = 4,
  parameter int unsigned ACW = 8
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           wr_en_i,
  input logic           rd_en_i,
  input logic [AW-1:0]  addr_i,
  input logic [31:0]    wdata_i,
  input logic [31:0]    rdata_o,
  input logic           busy_i,
  input logic           computing_i,
  input logic           input_phase_i,
  input logic [31:0]    dout_data_i,
  input logic           en_o,
  input logic [2:0]     chmod_o,
  input logic [2:0]     key_sel_o,
  input logic           rd_err_o,
  input logic           irq_o
);
  logic ctrl_wr, dout_rd;
  assign ctrl_wr = wr_en_i & (addr_i == AW'(0)) & ~wdata_i[31];
  assign dout_rd = rd_en_i & (addr_i == AW'(4));

  AST_BUSY_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && busy_i) |=> ($stable(chmod_o) && $stable(key_sel_o))); // R4

  AST_EN_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_wr && en_o && wdata_i[0]) |=> ($stable(chmod_o) && $stable(en_o))); // R5

  AST_BAD_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_rd && (computing_i || input_phase_i)) |=> (rdata_o == 32'd0)); // R6

  AST_GOOD_READ_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_rd && !computing_i && !input_phase_i) |=> (rdata_o == $past(dout_data_i))); // R6

  AST_ICR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == AW'(3) && wdata_i[0]) |=> !rd_err_o); // R7

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(rd_err_o)); // R8
endmodule

bind crypto_ctrl_regs crypto_ctrl_regs_chk #(.AW(AW), .ACW(ACW)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .rd_en_i       (rd_en_i),
  .addr_i        (addr_i),
  .wdata_i       (wdata_i),
  .rdata_o       (rdata_o),
  .busy_i        (busy_i),
  .computing_i   (computing_i),
  .input_phase_i (input_phase_i),
  .dout_data_i   (dout_data_i),
  .en_o          (en_o),
  .chmod_o       (chmod_o),
  .key_sel_o     (key_sel_o),
  .rd_err_o      (rd_err_o),
  .irq_o         (irq_o)
);

// File: tb/crypto_ctrl_regs_tb_top.sv
module crypto_ctrl_regs_tb_top;
  localparam int unsigned AW  = 4;
  localparam int unsigned ACW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0] wdata = '0, dout_data = '0;
  logic busy = 1'b0, computing = 1'b0, in_phase = 1'b0;
  logic [31:0] rdata;
  logic en, dma_in, rd_err, irq;
  logic [1:0] mode;
  logic [2:0] chmod, key_sel;
  logic [ACW-1:0] acc;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;
  logic rd_d = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #10 clk = ~clk;

  crypto_ctrl_regs #(.AW(AW), .ACW(ACW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_i(busy),
    .computing_i(computing), .input_phase_i(in_phase), .dout_data_i(dout_data),
    .en_o(en), .mode_o(mode), .chmod_o(chmod), .key_sel_o(key_sel),
    .dma_in_en_o(dma_in), .access_cfg_o(acc), .rd_err_o(rd_err), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input int a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_en = 1'b1; addr = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // scoreboard monitor
  always @(posedge clk) rd_d <= rd_en;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) chk("scoreboard underflow", 32'd1, 32'd0);
      else chk(tag_q.pop_front(), rdata, exp_q.pop_front());
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1
    chk("R1 en", 32'(en), 0);
    chk("R1 rd_err", 32'(rd_err), 0);
    chk("R1 irq", 32'(irq), 0);
    bus_rd(0, 32'h0, "R1 ctrl");
    bus_rd(1, 32'h0, "R1 status");
    bus_rd(2, 32'h0, "R1 ie");
    // R2
    bus_wr(0, 32'h7FFF_FFFE);
    bus_rd(0, 32'h7F0D_787E, "R2 masked ctrl");
    chk("R2 key_sel", 32'(key_sel), 7);
    chk("R2 mode", 32'(mode), 3);
    chk("R2 dma_in", 32'(dma_in), 1);
    // R3
    chk("R3 chmod all", 32'(chmod), 7);
    bus_wr(0, 32'h0001_0000);
    chk("R3 ccm", 32'(chmod), 4);
    bus_wr(0, 32'h0000_0040);
    chk("R3 ctr", 32'(chmod), 2);
    bus_wr(0, 32'h0000_0020);
    chk("R3 cbc", 32'(chmod), 1);
    // R4
    busy = 1'b1;
    bus_wr(0, 32'h0000_0060);
    chk("R4 chmod held", 32'(chmod), 1);
    bus_rd(0, 32'h0000_0020, "R4 ctrl held");
    busy = 1'b0;
    // R5
    bus_wr(0, 32'h0000_0001);
    chk("R5 en set", 32'(en), 1);
    chk("R5 chmod ecb", 32'(chmod), 0);
    bus_wr(0, 32'h0001_0061);
    chk("R5 locked chmod", 32'(chmod), 0);
    bus_rd(0, 32'h0000_0001, "R5 locked ctrl");
    bus_wr(0, 32'h0000_0060);
    chk("R5 unlock en", 32'(en), 0);
    chk("R5 unlock chmod", 32'(chmod), 3);
    bus_rd(0, 32'h0000_0060, "R5 unlock ctrl");
    // R9
    busy = 1'b1;
    bus_rd(1, 32'h1, "R9 status busy");
    bus_wr(1, 32'hFFFF_FFFF);
    bus_rd(1, 32'h1, "R9 status after write");
    busy = 1'b0;
    // R6
    dout_data = 32'hA5A5_1234;
    bus_rd(4, 32'hA5A5_1234, "R6 good read");
    chk("R6 no flag", 32'(rd_err), 0);
    computing = 1'b1;
    bus_rd(4, 32'h0, "R6 read while computing");
    computing = 1'b0;
    chk("R6 flag set", 32'(rd_err), 1);
    bus_rd(1, 32'h2, "R9 status flag");
    @(negedge clk);
    chk("R8 irq masked", 32'(irq), 0);
    // R7
    bus_wr(3, 32'h1);
    chk("R7 flag cleared", 32'(rd_err), 0);
    // R8
    bus_wr(2, 32'h1);
    bus_rd(2, 32'h1, "R8 ie readback");
    in_phase = 1'b1;
    bus_rd(4, 32'h0, "R6 read in input phase");
    in_phase = 1'b0;
    chk("R6 flag input phase", 32'(rd_err), 1);
    chk("R8 irq late", 32'(irq), 0);
    @(negedge clk);
    chk("R8 irq up", 32'(irq), 1);
    bus_wr(3, 32'h1);
    chk("R7 flag cleared again", 32'(rd_err), 0);
    chk("R8 irq still up", 32'(irq), 1);
    @(negedge clk);
    chk("R8 irq down", 32'(irq), 0);
    // R10
    bus_wr(5, 32'h0000_005A);
    computing = 1'b1;
    bus_rd(4, 32'h0, "R6 err before reset");
    computing = 1'b0;
    busy = 1'b1;
    bus_wr(0, 32'h8000_0000);
    busy = 1'b0;
    chk("R10 flag cleared", 32'(rd_err), 0);
    chk("R10 chmod cleared", 32'(chmod), 0);
    bus_rd(0, 32'h8000_0000, "R10 ctrl in reset");
    bus_rd(2, 32'h0, "R10 ie cleared");
    bus_wr(2, 32'h1);
    bus_wr(5, 32'h0000_0011);
    bus_rd(2, 32'h0, "R10 ie write ignored");
    bus_rd(5, 32'h0000_005A, "R10 access cfg kept");
    chk("R10 irq low", 32'(irq), 0);
    bus_wr(0, 32'h0000_0040);
    bus_rd(0, 32'h0, "R10 release ctrl zero");
    bus_wr(0, 32'h0000_0040);
    chk("R10 writable after release", 32'(chmod), 2);
    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule